// File: doc/BRIEF.md
# Output Compare Timer

The block is a timer peripheral built around a free-running 16-bit up-counter. A selectable power-of-two prescaler divides the system clock down to the counter tick. Several channels each hold a 16-bit compare value. When the counter takes a value equal to a channel's compare value, that channel raises a status flag and updates its output pin according to a two-bit action code. Software schedules the next event by reading the compare value, adding an interval and writing it back.

Status flags clear only through a two-step sequence. Software first reads the flag register while the flag is set, and then writes a one to that bit. This lets a polling loop acknowledge an event without losing one that arrives in between. A single level interrupt request combines the flags with per-channel mask bits.

Access is through a simple synchronous register port. Writes take effect on the clock edge where the write strobe is high. Read data is combinational from the address. A read of the flag register counts as a read on the clock edge where the read strobe is high.

Top module: `ocTimer`

## Requirements
- R1: After reset, the counter (address 5) reads 0x0000, every flag and every pin is low, and `irq` is low.
- R2: The counter advances only while the run bit is 1 (bit 15 of the configuration register at address 0). While the run bit is 0 the counter holds its value. A run bit written on one edge governs ticks from the following edge.
- R3: Configuration bits [2:0] hold a divider select s. The counter advances once every 2^s clocks. Its first advance comes on the 2^s-th edge after the edge that wrote run=1 (s=2 gives one advance per 4 clocks).
- R4: The counter wraps from 0xFFFF to 0x0000 and keeps running.
- R5: Channel n is a compare channel when bit n of the channel select register (address 2) is 1. Its compare value is at address 8+n. Bit n of the flag register (address 3) sets on the edge where the counter takes a value equal to that compare value. A channel whose select bit is 0 never sets its flag.
- R6: Bits [2n+1:2n] of the action register (address 1) give channel n's pin action on a match: 00 leaves the pin alone, 01 toggles it, 10 drives it 0 and 11 drives it 1. The pin changes on the same edge as the flag.
- R7: A write of 1 to flag bit n clears that flag only if the flag register was read while bit n was set, after the last write to the flag register. Writing 0, or writing 1 without such a read, leaves the flag set. Any write to the flag register uses up the earlier read.
- R8: A match on the same edge as a qualifying clearing write leaves the flag set.
- R9: Bit n of the mask register (address 4) enables channel n. `irq` is high exactly when some flag and its mask bit are both 1. With all mask bits 0, `irq` stays low while flags still set.
- R10: Compare registers read back the last value written at any time, including while the counter runs. Reads return data combinationally in the cycle of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (arms flag clearing) |
| busAddr | input | 4 | Register address |
| busWdata | input | 16 | Register write data |
| busRdata | output | 16 | Register read data for `busAddr` |
| chanPin | output | 4 | Compare output pins, one per channel |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that reset is low at the first clock edge. They also assume that only a write to the flag register can clear a flag, so any falling flag must follow such a write carrying a one in that bit. The stimulus never changes the divider select while the counter runs. It starts and stops the counter only with whole configuration writes, so every tick can be counted from the edge of the enabling write. The stimulus uses only defined addresses. It places each clearing write on a known counter value, so the match-versus-clear collision lands on an exact edge.

// File: rtl/ocTimerPkg.sv
package ocTimerPkg;

  localparam int MAX_CH = 8;
  localparam int CH_IDX_W = $clog2(MAX_CH);

  localparam int ADDR_CFG = 0;
  localparam int ADDR_ACT = 1;
  localparam int ADDR_SEL = 2;
  localparam int ADDR_FLAG = 3;
  localparam int ADDR_MASK = 4;
  localparam int ADDR_CNT = 5;
  localparam int ADDR_CMP_BASE = 8;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } ocAction_e;

  typedef struct packed {
    logic                flagWr;
    logic                flagRd;
    logic                cmpWr;
    logic [CH_IDX_W-1:0] cmpIdx;
  } ocStrobe_t;

endpackage

// File: rtl/ocTimerChan.sv
module ocTimerChan
  import ocTimerPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CHAN  = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] nextCount,
  input  logic             isOut,
  input  logic [1:0]       act,
  input  ocStrobe_t        strobe,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clrBit,
  output logic [CNT_W-1:0] cmpVal,
  output logic             flag,
  output logic             pin
);

  logic match;
  logic cmpHit;
  logic armed;
  ocAction_e action;

  assign cmpHit = strobe.cmpWr && (strobe.cmpIdx == CH_IDX_W'(CHAN));
  assign match  = tick && isOut && (nextCount == cmpVal);
  assign action = ocAction_e'(act);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= '0;
    end else if (cmpHit) begin
      cmpVal <= wdata;
    end
  end

  // Arm on a read that sees the flag set; any flag write consumes it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (strobe.flagWr) begin
      armed <= 1'b0;
    end else if (strobe.flagRd && flag) begin
      armed <= 1'b1;
    end
  end

  // A match outranks a clear on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (match) begin
      flag <= 1'b1;
    end else if (strobe.flagWr && clrBit && armed) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pin <= 1'b0;
    end else if (match) begin
      case (action)
        ACT_TOGGLE: pin <= ~pin;
        ACT_LOW:    pin <= 1'b0;
        ACT_HIGH:   pin <= 1'b1;
        default:    pin <= pin;
      endcase
    end
  end

endmodule

// File: rtl/ocTimerDp.sv
module ocTimerDp
  import ocTimerPkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      runEn,
  input  logic [SEL_W-1:0]          preSel,
  input  logic [NCH-1:0]            chanIsOut,
  input  logic [2*NCH-1:0]          chanAct,
  input  ocStrobe_t                 strobe,
  input  logic [CNT_W-1:0]          wdata,
  output logic [CNT_W-1:0]          countVal,
  output logic                      tick,
  output logic [NCH-1:0]            flagVec,
  output logic [NCH-1:0]            pinVec,
  output logic [NCH-1:0][CNT_W-1:0] cmpBank
);

  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divMask;
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      divMask[i] = (i < int'(preSel));
    end
  end

  assign tick      = runEn && ((preCnt & divMask) == divMask);
  assign nextCount = countVal + CNT_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!runEn) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (tick) begin
      countVal <= nextCount;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : gChan
    ocTimerChan #(
      .CNT_W(CNT_W),
      .CHAN (n)
    ) uChan (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (tick),
      .nextCount(nextCount),
      .isOut    (chanIsOut[n]),
      .act      (chanAct[2*n+:2]),
      .strobe   (strobe),
      .wdata    (wdata),
      .clrBit   (wdata[n]),
      .cmpVal   (cmpBank[n]),
      .flag     (flagVec[n]),
      .pin      (pinVec[n])
    );
  end

endmodule

// File: rtl/ocTimerCtrl.sv
module ocTimerCtrl
  import ocTimerPkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWr,
  input  logic                      busRd,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [CNT_W-1:0]          busWdata,
  output logic [CNT_W-1:0]          busRdata,
  input  logic [CNT_W-1:0]          countVal,
  input  logic [NCH-1:0]            flagVec,
  input  logic [NCH-1:0][CNT_W-1:0] cmpBank,
  output ocStrobe_t                 strobe,
  output logic                      runEn,
  output logic [SEL_W-1:0]          preSel,
  output logic [NCH-1:0]            chanIsOut,
  output logic [2*NCH-1:0]          chanAct,
  output logic [NCH-1:0]            irqMask,
  output logic                      irq
);

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CFG);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(ADDR_ACT);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(ADDR_SEL);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADDR_FLAG);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADDR_CNT);
  localparam logic [ADDR_W-1:0] A_CMP0 = ADDR_W'(ADDR_CMP_BASE);
  localparam logic [ADDR_W-1:0] N_CMP  = ADDR_W'(NCH);

  logic [ADDR_W-1:0]   cmpOff;
  logic                cmpRange;
  logic [CH_IDX_W-1:0] cmpIdx;

  assign cmpOff   = busAddr - A_CMP0;
  assign cmpRange = (busAddr >= A_CMP0) && (cmpOff < N_CMP);
  assign cmpIdx   = CH_IDX_W'(cmpOff);

  always_comb begin
    strobe.flagWr = busWr && (busAddr == A_FLAG);
    strobe.flagRd = busRd && (busAddr == A_FLAG);
    strobe.cmpWr  = busWr && cmpRange;
    strobe.cmpIdx = cmpIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      preSel    <= '0;
      chanIsOut <= '0;
      chanAct   <= '0;
      irqMask   <= '0;
    end else if (busWr) begin
      case (busAddr)
        A_CFG: begin
          runEn  <= busWdata[CNT_W-1];
          preSel <= busWdata[SEL_W-1:0];
        end
        A_SEL:   chanIsOut <= busWdata[NCH-1:0];
        A_ACT:   chanAct   <= busWdata[2*NCH-1:0];
        A_MASK:  irqMask   <= busWdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CFG: begin
        busRdata[CNT_W-1]   = runEn;
        busRdata[SEL_W-1:0] = preSel;
      end
      A_SEL:  busRdata[NCH-1:0]   = chanIsOut;
      A_ACT:  busRdata[2*NCH-1:0] = chanAct;
      A_FLAG: busRdata[NCH-1:0]   = flagVec;
      A_MASK: busRdata[NCH-1:0]   = irqMask;
      A_CNT:  busRdata            = countVal;
      default: begin
        for (int n = 0; n < NCH; n++) begin
          if (cmpRange && (cmpIdx == CH_IDX_W'(n))) begin
            busRdata = cmpBank[n];
          end
        end
      end
    endcase
  end

  assign irq = |(flagVec & irqMask);

endmodule

// File: rtl/ocTimer.sv
module ocTimer
  import ocTimerPkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NCH-1:0]    chanPin,
  output logic              irq
);

  ocStrobe_t                 strobe;
  logic                      runEn;
  logic [SEL_W-1:0]          preSel;
  logic [NCH-1:0]            chanIsOut;
  logic [2*NCH-1:0]          chanAct;
  logic [NCH-1:0]            irqMask;
  logic [CNT_W-1:0]          countVal;
  logic                      tick;
  logic [NCH-1:0]            flagVec;
  logic [NCH-1:0][CNT_W-1:0] cmpBank;

  ocTimerCtrl #(
    .NCH   (NCH),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .SEL_W (SEL_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .countVal (countVal),
    .flagVec  (flagVec),
    .cmpBank  (cmpBank),
    .strobe   (strobe),
    .runEn    (runEn),
    .preSel   (preSel),
    .chanIsOut(chanIsOut),
    .chanAct  (chanAct),
    .irqMask  (irqMask),
    .irq      (irq)
  );

  ocTimerDp #(
    .NCH  (NCH),
    .CNT_W(CNT_W),
    .SEL_W(SEL_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .preSel   (preSel),
    .chanIsOut(chanIsOut),
    .chanAct  (chanAct),
    .strobe   (strobe),
    .wdata    (busWdata),
    .countVal (countVal),
    .tick     (tick),
    .flagVec  (flagVec),
    .pinVec   (chanPin),
    .cmpBank  (cmpBank)
  );

endmodule

// File: rtl/ocTimerChk.sv
module ocTimerChk
  import ocTimerPkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busWr,
  input logic [ADDR_W-1:0]         busAddr,
  input logic [NCH-1:0]            clrData,
  input logic                      tick,
  input logic                      runEn,
  input logic [CNT_W-1:0]          countVal,
  input logic [NCH-1:0]            flagVec,
  input logic [NCH-1:0]            pinVec,
  input logic                      irq,
  input logic [NCH-1:0]            chanIsOut,
  input logic [2*NCH-1:0]          chanAct,
  input logic [NCH-1:0][CNT_W-1:0] cmpBank,
  input logic [NCH-1:0]            irqMask
);

  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0]  TOP    = '1;
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADDR_FLAG);

  logic [CNT_W-1:0] nextVal;
  logic             flagWrite;

  assign nextVal   = countVal + ONE;
  assign flagWrite = busWr && (busAddr == A_FLAG);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (countVal == '0 && flagVec == '0 && pinVec == '0 && !irq));

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(countVal));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countVal == TOP) |=> (countVal == '0));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqMask == '0) |-> !irq);

  for (genvar n = 0; n < NCH; n++) begin : gChk
    // R5
    match_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tick && chanIsOut[n] && nextVal == cmpBank[n]) |=> flagVec[n]);

    // R5
    idle_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!chanIsOut[n] && !flagVec[n]) |=> !flagVec[n]);

    // R6
    toggle_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tick && chanIsOut[n] && nextVal == cmpBank[n] && chanAct[2*n+:2] == 2'b01)
      |=> (pinVec[n] != $past(pinVec[n])));

    // R6
    high_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tick && chanIsOut[n] && nextVal == cmpBank[n] && chanAct[2*n+:2] == 2'b11)
      |=> pinVec[n]);

    // R7
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagVec[n]) |-> $past(flagWrite && clrData[n]));
  end

endmodule

bind ocTimer ocTimerChk #(
  .NCH   (NCH),
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .clrData  (busWdata[NCH-1:0]),
  .tick     (tick),
  .runEn    (runEn),
  .countVal (countVal),
  .flagVec  (flagVec),
  .pinVec   (chanPin),
  .irq      (irq),
  .chanIsOut(chanIsOut),
  .chanAct  (chanAct),
  .cmpBank  (cmpBank),
  .irqMask  (irqMask)
);

// File: tb/ocTimer_test.sv
module ocTimer_test;

  localparam logic [3:0] A_CFG = 4'd0, A_ACT = 4'd1, A_SEL = 4'd2, A_FLAG = 4'd3;
  localparam logic [3:0] A_MASK = 4'd4, A_CNT = 4'd5, A_CMP0 = 4'd8;
  localparam int K_REG = 0, K_PIN = 1, K_IRQ = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [3:0]  chanPin;
  logic        irq;
  logic        probeEn = 1'b0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ocTimer uut (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .chanPin (chanPin),
    .irq     (irq)
  );

  // Monitor: compares one queued item per observed cycle.
  always @(negedge clk) begin
    if (busRd || probeEn) begin
      logic [15:0] act;
      item_t it;
      if (sbq.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty actual=%h expected=item", busRdata);
      end else begin
        it = sbq.pop_front();
        case (it.kind)
          K_REG:   act = busRdata;
          K_PIN:   act = {12'h000, chanPin};
          default: act = {15'h0000, irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic endCycle();
    @(posedge clk);
    #1;
    busWr = 1'b0;
    busRd = 1'b0;
    probeEn = 1'b0;
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [15:0] d);
    busWr = 1'b1;
    busAddr = a;
    busWdata = d;
    endCycle();
  endtask

  task automatic rdReg(input logic [3:0] a, input logic [15:0] e, input string tag);
    sbq.push_back('{kind: K_REG, exp: e, tag: tag});
    busRd = 1'b1;
    busAddr = a;
    endCycle();
  endtask

  task automatic probe(input int k, input logic [15:0] e, input string tag);
    sbq.push_back('{kind: k, exp: e, tag: tag});
    probeEn = 1'b1;
    endCycle();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) endCycle();
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rdReg(A_CNT, 16'h0000, "R1 count after reset");
    rdReg(A_FLAG, 16'h0000, "R1 flags after reset");
    probe(K_PIN, 16'h0000, "R1 pins after reset");
    probe(K_IRQ, 16'h0000, "R1 irq after reset");

    // R10 compare read-back
    wrReg(A_CMP0, 16'h1234);
    wrReg(A_CMP0 + 4'd3, 16'hBEEF);
    rdReg(A_CMP0, 16'h1234, "R10 compare 0 readback");
    rdReg(A_CMP0 + 4'd3, 16'hBEEF, "R10 compare 3 readback");

    // R2 stopped counter holds
    idle(3);
    rdReg(A_CNT, 16'h0000, "R2 count held while stopped");

    // Channels 0..2 compare, channel 3 not; actions toggle/high/low/toggle
    wrReg(A_SEL, 16'h0007);
    wrReg(A_ACT, 16'h006D);
    for (int n = 0; n < 4; n++) wrReg(A_CMP0 + 4'(n), 16'h0003);
    wrReg(A_MASK, 16'h0000);
    wrReg(A_CFG, 16'h8000);
    idle(2);
    wrReg(A_CFG, 16'h0000);
    rdReg(A_CNT, 16'h0003, "R2 count stops after disable");
    probe(K_PIN, 16'h0003, "R6 toggle/high/low on match");
    probe(K_IRQ, 16'h0000, "R9 mask zero keeps irq low");

    // R7 two-step clear
    wrReg(A_FLAG, 16'h000F);
    rdReg(A_FLAG, 16'h0007, "R7 unarmed write keeps flags, R5 channel 3 idle");
    wrReg(A_FLAG, 16'h0000);
    rdReg(A_FLAG, 16'h0007, "R7 zero write keeps flags");
    wrReg(A_MASK, 16'h0004);
    probe(K_IRQ, 16'h0001, "R9 masked flag raises irq");
    wrReg(A_MASK, 16'h0008);
    probe(K_IRQ, 16'h0000, "R9 mask on clear flag");
    wrReg(A_FLAG, 16'h0001);
    rdReg(A_FLAG, 16'h0006, "R7 armed clear of bit 0");
    wrReg(A_FLAG, 16'h0006);
    rdReg(A_FLAG, 16'h0000, "R7 armed clear of bits 1 and 2");

    // R4 wrap: count 3, run at divide 1, stop on 0x0001
    wrReg(A_CFG, 16'h8000);
    idle(65530);
    rdReg(A_CNT, 16'hFFFD, "R4 count before wrap");
    idle(2);
    wrReg(A_CFG, 16'h0000);
    rdReg(A_CNT, 16'h0001, "R4 count after wrap");

    // R3 divide by 4: first advance on 4th edge after enable
    wrReg(A_CFG, 16'h8002);
    rdReg(A_CNT, 16'h0001, "R3 no advance on edge 0");
    rdReg(A_CNT, 16'h0001, "R3 no advance on edge 1");
    idle(1);
    rdReg(A_CNT, 16'h0001, "R3 no advance on edge 3");
    rdReg(A_CNT, 16'h0002, "R3 advance on edge 4");
    idle(2);
    rdReg(A_CNT, 16'h0002, "R3 held through edge 7");
    rdReg(A_CNT, 16'h0003, "R3 advance on edge 8");
    wrReg(A_CFG, 16'h0000);
    rdReg(A_CNT, 16'h0003, "R3 stopped between ticks");
    rdReg(A_FLAG, 16'h0007, "R5 flags set under prescale");
    wrReg(A_FLAG, 16'h0007);
    rdReg(A_FLAG, 16'h0000, "R7 clear after prescaled match");
    probe(K_PIN, 16'h0002, "R6 second match pins");

    // R8 match wins over clear on the same edge
    wrReg(A_CMP0, 16'h0004);
    wrReg(A_CFG, 16'h8000);
    wrReg(A_CMP0, 16'h0007);
    rdReg(A_FLAG, 16'h0001, "R5 flag 0 at count 4");
    probe(K_PIN, 16'h0003, "R6 toggle at count 4");
    wrReg(A_FLAG, 16'h0001);
    wrReg(A_CFG, 16'h0000);
    rdReg(A_FLAG, 16'h0001, "R8 match beats clear");
    probe(K_PIN, 16'h0002, "R6 toggle at count 7");
    rdReg(A_CMP0, 16'h0007, "R10 compare rewritten while running");

    // R6 hold / low / high codes: ch0=00, ch1=10, ch2=11
    wrReg(A_ACT, 16'h0078);
    for (int n = 0; n < 3; n++) wrReg(A_CMP0 + 4'(n), 16'h000A);
    wrReg(A_CFG, 16'h8000);
    idle(1);
    wrReg(A_CFG, 16'h0000);
    probe(K_PIN, 16'h0004, "R6 hold, drive low, drive high");
    rdReg(A_FLAG, 16'h0007, "R5 flags at count 10");
    probe(K_IRQ, 16'h0000, "R9 unmatched mask");
    wrReg(A_MASK, 16'h0002);
    probe(K_IRQ, 16'h0001, "R9 mask bit 1 raises irq");

    idle(2);
    if (sbq.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule